// File: doc/BRIEF.md
# Switched Decoupling Capacitor Controller

This block sequences three on-die capacitor pairs, each of which can be wired either in parallel or in series across the supply. In the quiet state every pair sits in parallel and behaves as an ordinary decoupling capacitor. An external comparator races a supply-sensitive delay line against a filtered reference line and raises a droop flag when the supply sags below the trip point. The controller samples that flag on every edge of the free-running reference ring clock. When the flag is seen, each pair that is armed for switching is moved into series so that it pushes charge onto the rail. When the flag clears, the pair is moved back into parallel and recharges from the rail.

Each pair is armed or left passive by a three-bit mask, so one, two or three pairs can take part. The same configuration word carries a resistor count. The count is expanded into a thermometer code that turns on parallel resistor devices in the reference filter, and more devices give a lower trip threshold. The configuration is shifted in serially and is committed with a strobe. The commit is accepted only while all pairs are in the quiet parallel state. The analog delay lines, filter, capacitors and switches lie outside the block.

Top module: `decap_switch_ctrl`

## Requirements
- R1: While reset is held and afterwards until the first commit, parCtl is all ones, serCtl is all zeros, no pair is armed, and resCode holds the mid-scale value (RES_BITS/2 ones in the low bits, 8'h0F by default).
- R2: While the synchronized droop flag is low and the block is quiet, every pair is held in parallel (parCtl all ones, serCtl zero).
- R3: A rise of droopIn before clock edge k passes two synchronizer flops. parCtl drops for the armed pairs at edge k+2, and serCtl rises for the same pairs at edge k+3.
- R4: A fall of droopIn before edge m drops serCtl of the armed pairs at edge m+2 and raises their parCtl again at edge m+3.
- R5: No pair ever has parCtl and serCtl high together. A pair's series control rises only when its parallel control was low in the previous cycle, and a pair's parallel control rises only when its series control was low in the previous cycle.
- R6: A pair that is not armed keeps parCtl high and serCtl low whatever droopIn does.
- R7: With no pair armed, droopIn has no effect on any output.
- R8: The configuration is shifted in on scanData, one bit per cycle with scanShift high, bit 0 first. Bits [2:0] arm pairs 2..0 (bit i arms pair i), and bits [6:3] give the resistor count. A scanCommit pulse in the quiet state applies the word at that clock edge. A commit takes precedence over a droop flag seen in the same cycle.
- R9: resCode bit j is high exactly when j is below the resistor count. A count above RES_BITS gives all ones.
- R10: A scanCommit that arrives while any pair is in series or in a transition gap is dropped. The armed mask and resCode keep their old values. The shifted word is kept and can be committed later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference ring-oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| droopIn | input | 1 | Asynchronous droop flag from the delay-line comparator |
| scanShift | input | 1 | Shift enable for the configuration shift register |
| scanData | input | 1 | Serial configuration data, bit 0 first |
| scanCommit | input | 1 | Request to apply the shifted configuration |
| parCtl | output | NUM_PAIRS | Parallel switch control per pair, high closes the parallel switches |
| serCtl | output | NUM_PAIRS | Series switch control per pair, high closes the series switch |
| resCode | output | RES_BITS | Thermometer code enabling filter resistor devices |

## Verification
A droop edge reaches the switch controls after a fixed latency. The release of one control is due three clock edges after the input change, and the application of the other control is due four edges after it. This is two synchronizer flops, then the state register with the first switch register, then the break-before-make gap. A committed configuration shows on resCode one edge after the commit pulse. The bench drives every input on the falling clock edge and steps whole cycles before it samples, also on the falling edge. It checks the output both one cycle before and on the exact cycle each change is due, for every armed mask and every resistor count.

// File: rtl/decap_pkg.sv
package decap_pkg;

  // Strobes from the sequencer to the switch/config datapath
  typedef struct packed {
    logic cfgLoad;   // apply shifted configuration
    logic dropPar;   // open parallel switches of armed pairs
    logic raiseSer;  // close series switch of armed pairs
    logic dropSer;   // open every series switch
    logic raisePar;  // close every parallel switch
  } swStrobe_t;

  typedef enum logic [1:0] {
    ST_PAR   = 2'd0,
    ST_GAP_S = 2'd1,
    ST_SER   = 2'd2,
    ST_GAP_P = 2'd3
  } swState_t;

endpackage

// File: rtl/decap_sync.sv
module decap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/decap_ctrl.sv
module decap_ctrl
  import decap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       droopSync,
  input  logic       anyArmed,
  input  logic       scanCommit,
  output swStrobe_t  stb
);
  swState_t state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_PAR: begin
        if (scanCommit) begin
          stb.cfgLoad = 1'b1;
        end else if (droopSync && anyArmed) begin
          stb.dropPar = 1'b1;
          stateNxt    = ST_GAP_S;
        end
      end
      ST_GAP_S: begin
        stb.raiseSer = 1'b1;
        stateNxt     = ST_SER;
      end
      ST_SER: begin
        if (!droopSync) begin
          stb.dropSer = 1'b1;
          stateNxt    = ST_GAP_P;
        end
      end
      ST_GAP_P: begin
        stb.raisePar = 1'b1;
        stateNxt     = ST_PAR;
      end
      default: stateNxt = ST_PAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PAR;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/decap_datapath.sv
module decap_datapath
  import decap_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int RES_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swStrobe_t            stb,
  input  logic                 scanShift,
  input  logic                 scanData,
  output logic                 anyArmed,
  output logic [NUM_PAIRS-1:0] armMask,
  output logic [NUM_PAIRS-1:0] parCtl,
  output logic [NUM_PAIRS-1:0] serCtl,
  output logic [RES_BITS-1:0]  resCode
);
  localparam int CNT_W = $clog2(RES_BITS + 1);
  localparam int CFG_W = NUM_PAIRS + CNT_W;
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(RES_BITS / 2);

  logic [CFG_W-1:0] shiftWord;
  logic [CNT_W-1:0] resCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftWord <= '0;
      armMask   <= '0;
      resCount  <= MID_CNT;
    end else begin
      if (scanShift) shiftWord <= {scanData, shiftWord[CFG_W-1:1]};
      if (stb.cfgLoad) begin
        armMask  <= shiftWord[NUM_PAIRS-1:0];
        resCount <= shiftWord[CFG_W-1:NUM_PAIRS];
      end
    end
  end

  assign anyArmed = |armMask;

  for (genvar j = 0; j < RES_BITS; j++) begin : g_therm
    assign resCode[j] = (resCount > CNT_W'(j));
  end

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rstN) begin
        parCtl[i] <= 1'b1;
        serCtl[i] <= 1'b0;
      end else begin
        if (stb.dropPar && armMask[i]) parCtl[i] <= 1'b0;
        if (stb.raisePar)              parCtl[i] <= 1'b1;
        if (stb.raiseSer && armMask[i]) serCtl[i] <= 1'b1;
        if (stb.dropSer)               serCtl[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/decap_switch_ctrl.sv
module decap_switch_ctrl
  import decap_pkg::*;
#(
  parameter int NUM_PAIRS   = 3,
  parameter int RES_BITS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 droopIn,
  input  logic                 scanShift,
  input  logic                 scanData,
  input  logic                 scanCommit,
  output logic [NUM_PAIRS-1:0] parCtl,
  output logic [NUM_PAIRS-1:0] serCtl,
  output logic [RES_BITS-1:0]  resCode
);
  logic                 droopSync;
  logic                 anyArmed;
  logic [NUM_PAIRS-1:0] armMask;
  swStrobe_t            stb;

  decap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(droopIn), .syncOut(droopSync)
  );

  decap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .droopSync(droopSync), .anyArmed(anyArmed),
    .scanCommit(scanCommit), .stb(stb)
  );

  decap_datapath #(.NUM_PAIRS(NUM_PAIRS), .RES_BITS(RES_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .scanShift(scanShift),
    .scanData(scanData), .anyArmed(anyArmed), .armMask(armMask),
    .parCtl(parCtl), .serCtl(serCtl), .resCode(resCode)
  );
endmodule

// File: rtl/decap_switch_chk.sv
module decap_switch_chk #(
  parameter int NUM_PAIRS = 3,
  parameter int RES_BITS  = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PAIRS-1:0] parCtl,
  input logic [NUM_PAIRS-1:0] serCtl,
  input logic [NUM_PAIRS-1:0] armMask,
  input logic [RES_BITS-1:0]  resCode
);
  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (parCtl & serCtl) == '0);

  // R5
  bbm_ser_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((serCtl & ~$past(serCtl)) & $past(parCtl)) == '0);

  // R5
  bbm_par_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((parCtl & ~$past(parCtl)) & $past(serCtl)) == '0);

  // R6
  passive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((serCtl | ~parCtl) & ~armMask) == '0);

  // R9
  therm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resCode & (resCode + RES_BITS'(1))) == '0);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|serCtl) |=> ($stable(resCode) && $stable(armMask)));
endmodule

bind decap_switch_ctrl decap_switch_chk #(.NUM_PAIRS(NUM_PAIRS), .RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .parCtl(parCtl), .serCtl(serCtl),
  .armMask(armMask), .resCode(resCode)
);

// File: tb/sim_decap_switch_ctrl.sv
`timescale 1ns/1ps
module sim_decap_switch_ctrl;
  logic clk = 1'b0;
  logic rstN, droopIn, scanShift, scanData, scanCommit;
  logic [2:0] parCtl, serCtl;
  logic [7:0] resCode;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  decap_switch_ctrl u0 (
    .clk(clk), .rstN(rstN), .droopIn(droopIn), .scanShift(scanShift),
    .scanData(scanData), .scanCommit(scanCommit),
    .parCtl(parCtl), .serCtl(serCtl), .resCode(resCode)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int therm(input int cnt);
    int c = (cnt > 8) ? 8 : cnt;
    return (1 << c) - 1;
  endfunction

  task automatic shiftCfg(input int mask, input int cnt);
    int word = (cnt << 3) | mask;
    for (int b = 0; b < 7; b++) begin
      scanShift = 1'b1;
      scanData  = word[b];
      step(1);
    end
    scanShift = 1'b0;
    scanData  = 1'b0;
  endtask

  task automatic commit();
    scanCommit = 1'b1;
    step(1);
    scanCommit = 1'b0;
  endtask

  // Full droop episode with per-cycle timing checks for armed mask m
  task automatic droopEpisode(input int m);
    int inv = 7 & ~m;
    droopIn = 1'b1;
    step(2);
    check("R3 before release", parCtl, 7);
    step(1);
    check("R3 par released", parCtl, inv);
    check("R3 ser still low", serCtl, 0);
    step(1);
    check("R3 ser applied", serCtl, m);
    check("R6 disabled pairs parallel", parCtl, inv);
    step(3);
    check("R3 series held", serCtl, m);
    droopIn = 1'b0;
    step(2);
    check("R4 series before release", serCtl, m);
    step(1);
    check("R4 ser released", serCtl, 0);
    check("R4 par still open", parCtl, inv);
    step(1);
    check("R4 par restored", parCtl, 7);
    check("R2 idle", serCtl, 0);
  endtask

  initial begin
    rstN = 1'b0; droopIn = 1'b0; scanShift = 1'b0; scanData = 1'b0; scanCommit = 1'b0;
    step(3);
    check("R1 reset par", parCtl, 7);
    check("R1 reset ser", serCtl, 0);
    check("R1 reset res", resCode, 8'h0F);
    rstN = 1'b1;
    step(1);
    // R7: nothing armed after reset, droop ignored
    droopIn = 1'b1;
    step(6);
    check("R7 par with no armed pair", parCtl, 7);
    check("R7 ser with no armed pair", serCtl, 0);
    droopIn = 1'b0;
    step(3);
    check("R2 idle par", parCtl, 7);

    // R8 sweep all masks with varied counts
    for (int m = 0; m < 8; m++) begin
      shiftCfg(m, 2 * m);
      commit();
      check("R8 commit res", resCode, therm(2 * m));
      droopEpisode(m);
    end

    // R9 full count sweep including saturation
    for (int c = 0; c < 16; c++) begin
      shiftCfg(0, c);
      commit();
      check("R9 thermometer", resCode, therm(c));
    end

    // R8 commit wins over a same-cycle droop
    shiftCfg(3, 1);
    droopIn = 1'b1;
    step(2);
    scanCommit = 1'b1;
    step(1);
    scanCommit = 1'b0;
    check("R8 commit priority res", resCode, therm(1));
    check("R8 commit priority par", parCtl, 7);
    step(1);
    check("R8 droop follows commit", parCtl, 4);
    step(1);
    check("R8 series after commit", serCtl, 3);
    droopIn = 1'b0;
    step(5);
    check("R4 back parallel", parCtl, 7);

    // R10 commit during series is dropped
    shiftCfg(5, 2);
    commit();
    droopIn = 1'b1;
    step(4);
    check("R10 series entered", serCtl, 5);
    shiftCfg(2, 7);
    commit();
    check("R10 res unchanged", resCode, therm(2));
    droopIn = 1'b0;
    step(4);
    check("R10 parallel again", parCtl, 7);
    droopIn = 1'b1;
    step(4);
    check("R10 old mask kept", serCtl, 5);
    droopIn = 1'b0;
    step(4);
    commit();
    check("R10 retained word res", resCode, therm(7));
    droopIn = 1'b1;
    step(4);
    check("R10 retained word mask", serCtl, 2);
    droopIn = 1'b0;
    step(4);
    check("R2 final idle", parCtl, 7);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule